// File: doc/BRIEF.md
# Shared Section Interrupt Aggregator

This block gathers interrupt events from a group of ports and merges them onto shared active-low request lines, one for each section. Every port owns two registers. A control register holds a master enable for the whole port and one enable bit for each event source. A status register latches event pulses. Software reaches both registers through a simple strobe-based read/write interface. Reading the status register clears it.

A port requests service only when its master enable is set and at least one pending status bit has its source enable set. All requesting ports in a section drive the same line low. The line does not say which port asked, so software must poll the status registers to find the source. A static strap input picks the mode. In split mode the lower half of the ports drives one line and the upper half drives the other. In joined mode both lines carry the same value, which is merged over every port.

Top module: `irqagg_top`

## Requirements
- R1: After synchronous reset, both `irq_n` bits are 1, and every control and status register reads 0.
- R2: A one-cycle pulse on `evt_pulse[p*NSRC+k]` sets status bit k of port p. A read strobe with `reg_sel`=1 returns that port's status in `reg_rdata[NSRC-1:0]` one cycle after the strobe, with the upper bits 0.
- R3: A status read clears the port's status register, so an immediate second read returns 0.
- R4: An event that arrives in the same cycle as a status read of its port is not lost. That read returns the old value, and the next read shows the event's bit.
- R5: When control bit 1 (master enable) of a port is 0, that port never pulls `irq_n` low, whatever its status holds.
- R6: Control bit k+2 enables source k. A pending status bit whose enable bit is 0 does not pull `irq_n` low, but it is still latched and readable.
- R7: `irq_n` goes low on the clock edge after the edge that latches a qualifying event. It returns high on the edge after the status read that removes the last qualifying bit.
- R8: With `sect_mode`=1, `irq_n[0]` is driven only by ports 0..NPORT/2-1, and `irq_n[1]` only by the upper ports.
- R9: With `sect_mode`=0, both `irq_n` bits are equal and are low when any port in the block qualifies.
- R10: Writes with `reg_sel`=1 have no effect on status. A control write keeps only bit 1 and bits 2..NSRC+1, and all other control bits read back as 0.
- R11: Reading the control register (`reg_sel`=0) leaves the status register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sect_mode | input | 1 | Strap: 1 = split into two sections, 0 = joined; held steady outside reset |
| evt_pulse | input | NPORT*NSRC | One-cycle event pulses, port p source k at bit p*NSRC+k |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_port | input | $clog2(NPORT) | Port index for the access |
| reg_sel | input | 1 | 0 = control register, 1 = status register |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data, valid the cycle after the read strobe |
| irq_n | output | 2 | Active-low shared requests, one per section |

## Verification
A status bit stuck at 1 shows up as an `irq_n` line that stays low after the clearing read, one edge later. It also shows up as a non-zero second read. A lost event shows as a line that stays high two edges after the pulse, and as a zero read. A wrong master or source-enable gate shows at the output in the same two-edge window. A mis-wired section shows as the wrong `irq_n` bit falling. Each scenario therefore samples the lines exactly one and two edges after the event or the read, and reads the registers back right after that.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  // Bit position of the port-wide master enable inside the control register
  localparam int unsigned MASTER_BIT = 1;
  // First per-source enable bit inside the control register
  localparam int unsigned SRC_EN_LSB = 2;

  typedef enum logic {
    SEL_CTL  = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;

endpackage

// File: rtl/irqagg_port_regs.sv
module irqagg_port_regs
  import irqagg_pkg::*;
#(
  parameter int unsigned NSRC  = 5,
  parameter int unsigned REG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             sel,
  input  logic [REG_W-1:0] wdata,
  input  logic [NSRC-1:0]  evt,
  output logic [REG_W-1:0] ctl_q,
  output logic [NSRC-1:0]  stat_q
);

  localparam logic [REG_W-1:0] SRC_FIELD = REG_W'(((1 << NSRC) - 1) << SRC_EN_LSB);
  localparam logic [REG_W-1:0] CTL_KEEP  = SRC_FIELD | (REG_W'(1) << MASTER_BIT);

  logic stat_clr;
  logic ctl_load;

  assign stat_clr = rd_en && (sel == SEL_STAT);
  assign ctl_load = wr_en && (sel == SEL_CTL);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (ctl_load) begin
      ctl_q <= wdata & CTL_KEEP;
    end
  end

  // A new event wins over the clear from a read in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
    end else begin
      stat_q <= (stat_clr ? '0 : stat_q) | evt;
    end
  end

endmodule

// File: rtl/irqagg_qualify.sv
module irqagg_qualify
  import irqagg_pkg::*;
#(
  parameter int unsigned NSRC  = 5,
  parameter int unsigned REG_W = 16
) (
  input  logic [REG_W-1:0] ctl,
  input  logic [NSRC-1:0]  stat,
  output logic             req,
  output logic             master
);

  logic [NSRC-1:0] src_en;
  logic [NSRC-1:0] live;

  assign src_en = ctl[SRC_EN_LSB +: NSRC];
  assign master = ctl[MASTER_BIT];
  assign live   = stat & src_en;
  assign req    = master && (|live);

endmodule

// File: rtl/irqagg_pin_merge.sv
module irqagg_pin_merge #(
  parameter int unsigned NPORT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sect_mode,
  input  logic [NPORT-1:0] req,
  output logic [1:0]       irq_n
);

  localparam int unsigned HALF = NPORT / 2;

  logic any_lo;
  logic any_hi;
  logic any_all;
  logic [1:0] pin_req;

  assign any_lo  = |req[HALF-1:0];
  assign any_hi  = |req[NPORT-1:HALF];
  assign any_all = any_lo || any_hi;

  always_comb begin
    if (sect_mode) begin
      pin_req = {any_hi, any_lo};
    end else begin
      pin_req = {any_all, any_all};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_n <= 2'b11;
    end else begin
      irq_n <= ~pin_req;
    end
  end

endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
#(
  parameter int unsigned NPORT = 8,
  parameter int unsigned NSRC  = 5,
  parameter int unsigned REG_W = 16,
  localparam int unsigned PW   = $clog2(NPORT)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sect_mode,
  input  logic [NPORT*NSRC-1:0] evt_pulse,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [PW-1:0]         reg_port,
  input  logic                  reg_sel,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  output logic [1:0]            irq_n
);

  logic [REG_W-1:0] ctl_q  [NPORT];
  logic [NSRC-1:0]  stat_q [NPORT];
  logic [NPORT-1:0] port_req;
  logic [NPORT-1:0] ctl_master;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic hit;
    assign hit = (reg_port == PW'(p));

    irqagg_port_regs #(
      .NSRC (NSRC),
      .REG_W(REG_W)
    ) u_regs (
      .clk   (clk),
      .rst   (rst),
      .wr_en (reg_wr && hit),
      .rd_en (reg_rd && hit),
      .sel   (reg_sel),
      .wdata (reg_wdata),
      .evt   (evt_pulse[p*NSRC +: NSRC]),
      .ctl_q (ctl_q[p]),
      .stat_q(stat_q[p])
    );

    irqagg_qualify #(
      .NSRC (NSRC),
      .REG_W(REG_W)
    ) u_qual (
      .ctl   (ctl_q[p]),
      .stat  (stat_q[p]),
      .req   (port_req[p]),
      .master(ctl_master[p])
    );
  end

  irqagg_pin_merge #(
    .NPORT(NPORT)
  ) u_merge (
    .clk      (clk),
    .rst      (rst),
    .sect_mode(sect_mode),
    .req      (port_req),
    .irq_n    (irq_n)
  );

  // Registered read data, held between read strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      if (reg_sel == SEL_STAT) begin
        reg_rdata <= REG_W'(stat_q[reg_port]);
      end else begin
        reg_rdata <= ctl_q[reg_port];
      end
    end
  end

endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker #(
  parameter int unsigned NPORT = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             sect_mode,
  input logic [1:0]       irq_n,
  input logic [NPORT-1:0] port_req,
  input logic [NPORT-1:0] ctl_master
);

  localparam int unsigned HALF = NPORT / 2;

  // R1: the lines are idle right after a reset cycle
  p_reset_idle_r1: assert property (@(posedge clk) rst |=> (irq_n == 2'b11));

  // R5: a port without master enable never requests
  p_master_gate_r5: assert property (@(posedge clk) disable iff (rst)
    ((port_req & ~ctl_master) == '0));

  // R7: any request pulls a line low on the next edge
  p_req_to_pin_r7: assert property (@(posedge clk) disable iff (rst)
    (|port_req) |=> (irq_n != 2'b11));

  // R7: no request releases both lines on the next edge
  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    !(|port_req) |=> (irq_n == 2'b11));

  // R8: in split mode the lower line ignores the upper ports
  p_lower_section_r8: assert property (@(posedge clk) disable iff (rst)
    (sect_mode && !(|port_req[HALF-1:0])) |=> irq_n[0]);

  // R9: in joined mode the two lines agree
  p_joined_equal_r9: assert property (@(posedge clk) disable iff (rst)
    (!sect_mode && !$past(rst) && $stable(sect_mode)) |-> (irq_n[0] == irq_n[1]));

endmodule

bind irqagg_top irqagg_checker #(.NPORT(NPORT)) u_chk (.*);

// File: tb/sim_irqagg_top.sv
`timescale 1ns/1ps
module sim_irqagg_top;

  localparam int unsigned NPORT = 8;
  localparam int unsigned NSRC  = 5;
  localparam int unsigned REG_W = 16;
  localparam int unsigned PW    = $clog2(NPORT);
  localparam logic [REG_W-1:0] CTL_ALL = 16'h007E;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic                  sect_mode = 1'b1;
  logic [NPORT*NSRC-1:0] evt_pulse = '0;
  logic                  reg_wr = 1'b0;
  logic                  reg_rd = 1'b0;
  logic [PW-1:0]         reg_port = '0;
  logic                  reg_sel = 1'b0;
  logic [REG_W-1:0]      reg_wdata = '0;
  logic [REG_W-1:0]      reg_rdata;
  logic [1:0]            irq_n;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  irqagg_top #(.NPORT(NPORT), .NSRC(NSRC), .REG_W(REG_W)) u0 (
    .clk(clk), .rst(rst), .sect_mode(sect_mode), .evt_pulse(evt_pulse),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_port(reg_port), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset(input logic mode);
    rst = 1'b1;
    sect_mode = mode;
    repeat (3) tick();
    rst = 1'b0;
  endtask

  task automatic wr(input int port, input logic sel, input logic [REG_W-1:0] d);
    reg_port = PW'(port); reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int port, input logic sel, output logic [REG_W-1:0] d);
    reg_port = PW'(port); reg_sel = sel; reg_rd = 1'b1;
    tick();
    d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic pulse(input int port, input int src);
    evt_pulse[port*NSRC+src] = 1'b1;
    tick();
    evt_pulse = '0;
  endtask

  task automatic t_reset();
    logic [REG_W-1:0] d;
    do_reset(1'b1);
    chk("R1 irq_n idle", 32'(irq_n), 32'h3);
    rd(3, 1'b0, d); chk("R1 ctl zero", 32'(d), 32'h0);
    rd(7, 1'b1, d); chk("R1 status zero", 32'(d), 32'h0);
  endtask

  task automatic t_latch_and_clear();
    logic [REG_W-1:0] d;
    pulse(2, 3);
    rd(2, 1'b0, d); chk("R11 ctl read value", 32'(d), 32'h0);
    rd(2, 1'b1, d); chk("R2 status bit3", 32'(d), 32'h8);
    rd(2, 1'b1, d); chk("R3 cleared", 32'(d), 32'h0);
    pulse(2, 0);
    pulse(2, 4);
    rd(2, 1'b0, d);
    rd(2, 1'b1, d); chk("R11 status kept after ctl read", 32'(d), 32'h11);
  endtask

  task automatic t_irq_timing();
    logic [REG_W-1:0] d;
    wr(1, 1'b0, CTL_ALL);
    pulse(1, 0);
    chk("R7 not yet low", 32'(irq_n), 32'h3);
    tick();
    chk("R7 low one edge later", 32'(irq_n), 32'h2);
    chk("R8 upper line idle", 32'(irq_n[1]), 32'h1);
    rd(1, 1'b1, d); chk("R2 status bit0", 32'(d), 32'h1);
    chk("R7 still low at read edge", 32'(irq_n), 32'h2);
    tick();
    chk("R7 released after clear", 32'(irq_n), 32'h3);
  endtask

  task automatic t_master_off();
    logic [REG_W-1:0] d;
    wr(1, 1'b0, CTL_ALL & ~16'h0002);
    pulse(1, 2);
    tick(); tick();
    chk("R5 no request without master", 32'(irq_n), 32'h3);
    rd(1, 1'b1, d); chk("R5 status still latched", 32'(d), 32'h4);
  endtask

  task automatic t_source_mask();
    logic [REG_W-1:0] d;
    wr(1, 1'b0, 16'h003E);
    pulse(1, 4);
    tick(); tick();
    chk("R6 masked source silent", 32'(irq_n), 32'h3);
    pulse(1, 2);
    tick();
    chk("R6 enabled source requests", 32'(irq_n), 32'h2);
    rd(1, 1'b1, d); chk("R6 both bits latched", 32'(d), 32'h14);
    tick();
    chk("R6 released", 32'(irq_n), 32'h3);
  endtask

  task automatic t_section();
    logic [REG_W-1:0] d;
    wr(6, 1'b0, CTL_ALL);
    pulse(6, 1);
    tick();
    chk("R8 upper port drives line 1 only", 32'(irq_n), 32'h1);
    rd(6, 1'b1, d);
    tick();
    chk("R8 released", 32'(irq_n), 32'h3);
  endtask

  task automatic t_collide();
    logic [REG_W-1:0] d;
    reg_port = PW'(4); reg_sel = 1'b1; reg_rd = 1'b1;
    evt_pulse[4*NSRC+3] = 1'b1;
    tick();
    d = reg_rdata;
    reg_rd = 1'b0; evt_pulse = '0;
    chk("R4 read returns old value", 32'(d), 32'h0);
    rd(4, 1'b1, d); chk("R4 event kept", 32'(d), 32'h8);
  endtask

  task automatic t_write_rules();
    logic [REG_W-1:0] d;
    wr(3, 1'b1, 16'hFFFF);
    rd(3, 1'b1, d); chk("R10 status write ignored", 32'(d), 32'h0);
    wr(3, 1'b0, 16'hFFFF);
    rd(3, 1'b0, d); chk("R10 ctl keeps defined bits", 32'(d), 32'(CTL_ALL));
  endtask

  task automatic t_joined();
    logic [REG_W-1:0] d;
    do_reset(1'b0);
    wr(5, 1'b0, CTL_ALL);
    pulse(5, 0);
    tick();
    chk("R9 upper port drives both", 32'(irq_n), 32'h0);
    rd(5, 1'b1, d);
    tick();
    chk("R9 both released", 32'(irq_n), 32'h3);
    wr(0, 1'b0, CTL_ALL);
    pulse(0, 3);
    tick();
    chk("R9 lower port drives both", 32'(irq_n), 32'h0);
    rd(0, 1'b1, d);
    tick();
    chk("R9 released again", 32'(irq_n), 32'h3);
  endtask

  initial begin
    tick();
    t_reset();
    t_latch_and_clear();
    t_irq_timing();
    t_master_off();
    t_source_mask();
    t_section();
    t_collide();
    t_write_rules();
    t_joined();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule